// File: doc/BRIEF.md
# Four-Phase Fetch/Execute Program Sequencer

This block paces a small processor core. It divides the system clock into instruction cycles of four clocks each, and marks every cycle with four non-overlapping phase strobes, T1 to T4. It runs a two-stage pipeline. While the word at the program counter is fetched, the word fetched in the previous cycle is executed. The block holds the program counter. At each instruction-cycle boundary it picks the next fetch address from one of these sources: the plain increment, a skip, a jump or call target, a low-byte write, a return address, or an interrupt vector.

Any change of flow throws away the word that was already prefetched. That word then turns into a dead execute cycle, so a taken transfer costs two instruction cycles. After reset, the block waits for a start-up interval before the first fetch. The decoder around the block drives the request inputs from the word it is executing. The block drives `exec_valid` low in any cycle whose execute slot holds a squashed word.

Top module: `fetch_sequencer`

## Requirements
- R1: `phase_o` is one-hot while running, with bit 0 = T1, bit 1 = T2, bit 2 = T3 and bit 3 = T4. It steps T1, T2, T3, T4 and back to T1, one phase per clock, so one instruction cycle is four clocks. It is all zero while held off.
- R2: The asynchronous reset is released through a two-flop synchronizer. After that release, the block waits a hold-off of `STARTUP` clocks. The first T1, with `fetch_stb` high, appears after rising clock edge number `STARTUP`+2, counting from the first edge after `rst_n` rises.
- R3: In reset and during the hold-off, `fetch_stb`, `push_stb` and `exec_valid` are low. The first cycle fetches address 0 with `exec_valid` low.
- R4: `fetch_stb` is high in T1 only. `fetch_addr` equals the program counter and stays constant through the whole instruction cycle. The program counter changes only on the T4-to-T1 edge, and request inputs are sampled on that edge.
- R5: `instr_i`, sampled on the T4-to-T1 edge, appears on `exec_instr` during the next cycle. With no request, the next address is the current one plus 1 and the next execute slot is valid.
- R6: While `exec_valid` is high, a flow request loads its target and the next execute slot is invalid. Priority among flow requests is `call_req` and `jmp_req` (both load `tgt_addr`, with call first), then `ret_req` (loads `ret_addr`), then `pcl_wr`. `pcl_wr` replaces the low `LOW_W` bits of the program counter with `pcl_data` and keeps the upper bits.
- R7: While `exec_valid` is high, `skip_req` with no flow request advances the address by 1 and invalidates the next execute slot.
- R8: While `exec_valid` is low, the call, jump, return, low-byte and skip requests are ignored.
- R9: `irq_req` is taken on the T4-to-T1 edge unless the valid executing word requests a call, in which case it waits. A taken interrupt loads `irq_vec`, invalidates the next execute slot, and pushes a resume address. The resume address is the flow target if a flow request is active; otherwise it is the current address plus 1 after a valid skip; otherwise it is the current address.
- R10: `push_stb` is high during T4 of a cycle that takes an interrupt or executes a valid call. A call pushes the current program counter.
- R11: Next-address priority is interrupt, then flow target, then skip, then increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | IW | Program word read at `fetch_addr` |
| call_req | input | 1 | Executing word is a subroutine call |
| jmp_req | input | 1 | Executing word is a jump |
| ret_req | input | 1 | Executing word returns from subroutine |
| pcl_wr | input | 1 | Executing word writes the PC low byte |
| skip_req | input | 1 | Executing word skips, condition true |
| irq_req | input | 1 | Interrupt request, internal or external |
| tgt_addr | input | PC_W | Jump or call target |
| ret_addr | input | PC_W | Return address from the stack |
| pcl_data | input | LOW_W | New low bits of the program counter |
| irq_vec | input | PC_W | Interrupt vector address |
| phase_o | output | 4 | Phase strobes, bit 0 = T1 through bit 3 = T4 |
| fetch_stb | output | 1 | Fetch strobe, high in T1 |
| fetch_addr | output | PC_W | Program counter, the current fetch address |
| exec_valid | output | 1 | Execute slot holds a live word |
| exec_instr | output | IW | Word in the execute slot |
| push_stb | output | 1 | Push a return address, high in T4 |
| push_addr | output | PC_W | Address to push |

## Verification
The hardest case to reach is a request that lands in a squashed execute slot. That case only exists in the single cycle right after a transfer, skip or interrupt. The bench reaches it by issuing a jump and then holding jump, skip and interrupt requests into the bubble that follows. The deferred interrupt behind a call, and the resume address after an interrupt that coincides with a skip or a jump, are built the same way, one cycle at a time. A long stretch of pseudo-random request mixes then compares every cycle against an arithmetic model.

// File: rtl/fseq_pkg.sv
package fseq_pkg;
  typedef enum logic [1:0] {
    NX_INC  = 2'd0,
    NX_SKIP = 2'd1,
    NX_XFER = 2'd2,
    NX_IRQ  = 2'd3
  } nx_sel_e;
endpackage

// File: rtl/fseq_rst_sync.sv
module fseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic s0, s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0 <= 1'b0;
      s1 <= 1'b0;
    end else begin
      s0 <= 1'b1;
      s1 <= s0;
    end
  end

  assign rst_n_s = s1;
endmodule

// File: rtl/fseq_phase.sv
module fseq_phase #(
  parameter int STARTUP = 1024
) (
  input  logic       clk,
  input  logic       rst_n_s,
  output logic [3:0] phase_o,
  output logic       boundary
);
  localparam int CW = (STARTUP > 1) ? $clog2(STARTUP) : 1;

  logic          running, run_d;
  logic [1:0]    ph, ph_d;
  logic [CW-1:0] cnt, cnt_d;

  always_comb begin
    run_d = running;
    ph_d  = ph;
    cnt_d = cnt;
    if (!running) begin
      if (cnt == CW'(STARTUP - 1)) run_d = 1'b1;
      else                         cnt_d = cnt + CW'(1);
    end else begin
      ph_d = ph + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      running <= 1'b0;
      ph      <= 2'd0;
      cnt     <= '0;
    end else begin
      running <= run_d;
      ph      <= ph_d;
      cnt     <= cnt_d;
    end
  end

  assign phase_o  = running ? (4'b0001 << ph) : 4'b0000;
  assign boundary = running && (ph == 2'd3);

  // R1: phases rotate T1..T4 one per clock once running
  p_phase_order_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    (phase_o != 4'b0000) |=> (phase_o == {$past(phase_o[2:0]), $past(phase_o[3])}));

  // R2: no phase while the start-up count is still short of its end
  p_holdoff_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!running && cnt != CW'(STARTUP - 1)) |=> (phase_o == 4'b0000));
endmodule

// File: rtl/fseq_next_pc.sv
module fseq_next_pc
  import fseq_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int LOW_W = 8
) (
  input  logic [PC_W-1:0]  pc,
  input  logic             ev,
  input  logic             call_req,
  input  logic             jmp_req,
  input  logic             ret_req,
  input  logic             pcl_wr,
  input  logic             skip_req,
  input  logic             irq_req,
  input  logic [PC_W-1:0]  tgt_addr,
  input  logic [PC_W-1:0]  ret_addr,
  input  logic [LOW_W-1:0] pcl_data,
  input  logic [PC_W-1:0]  irq_vec,
  output logic [PC_W-1:0]  pc_nx,
  output logic             ev_nx,
  output logic             push_req,
  output logic [PC_W-1:0]  push_addr,
  output nx_sel_e          sel
);
  logic [PC_W-1:0] pcl_tgt, flow_tgt, resume, pc_inc;
  logic            do_call, do_jmp, do_ret, do_pcl, do_skip, flow, take_irq;

  generate
    if (PC_W <= LOW_W) begin : g_full
      assign pcl_tgt = pcl_data[PC_W-1:0];
    end else begin : g_low
      assign pcl_tgt = {pc[PC_W-1:LOW_W], pcl_data};
    end
  endgenerate

  assign pc_inc = pc + PC_W'(1);

  always_comb begin
    do_call  = ev && call_req;
    do_jmp   = ev && jmp_req;
    do_ret   = ev && ret_req;
    do_pcl   = ev && pcl_wr;
    do_skip  = ev && skip_req;
    flow     = do_call || do_jmp || do_ret || do_pcl;
    take_irq = irq_req && !do_call;

    if (do_call || do_jmp) flow_tgt = tgt_addr;
    else if (do_ret)       flow_tgt = ret_addr;
    else                   flow_tgt = pcl_tgt;

    if (flow)         resume = flow_tgt;
    else if (do_skip) resume = pc_inc;
    else              resume = pc;

    if (take_irq)     sel = NX_IRQ;
    else if (flow)    sel = NX_XFER;
    else if (do_skip) sel = NX_SKIP;
    else              sel = NX_INC;

    unique case (sel)
      NX_IRQ:  begin pc_nx = irq_vec;  ev_nx = 1'b0; end
      NX_XFER: begin pc_nx = flow_tgt; ev_nx = 1'b0; end
      NX_SKIP: begin pc_nx = pc_inc;   ev_nx = 1'b0; end
      default: begin pc_nx = pc_inc;   ev_nx = 1'b1; end
    endcase

    push_req  = take_irq || do_call;
    push_addr = take_irq ? resume : pc;
  end
endmodule

// File: rtl/fetch_sequencer.sv
module fetch_sequencer
  import fseq_pkg::*;
#(
  parameter int PC_W    = 12,
  parameter int LOW_W   = 8,
  parameter int IW      = 14,
  parameter int STARTUP = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IW-1:0]    instr_i,
  input  logic             call_req,
  input  logic             jmp_req,
  input  logic             ret_req,
  input  logic             pcl_wr,
  input  logic             skip_req,
  input  logic             irq_req,
  input  logic [PC_W-1:0]  tgt_addr,
  input  logic [PC_W-1:0]  ret_addr,
  input  logic [LOW_W-1:0] pcl_data,
  input  logic [PC_W-1:0]  irq_vec,
  output logic [3:0]       phase_o,
  output logic             fetch_stb,
  output logic [PC_W-1:0]  fetch_addr,
  output logic             exec_valid,
  output logic [IW-1:0]    exec_instr,
  output logic             push_stb,
  output logic [PC_W-1:0]  push_addr
);
  logic            rst_n_s, boundary, ev_nx, push_req;
  logic [PC_W-1:0] pc, pc_nx, pc_d;
  logic            ev, ev_d;
  logic [IW-1:0]   ins, ins_d;
  nx_sel_e         sel;

  fseq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  fseq_phase #(.STARTUP(STARTUP)) u_phase (
    .clk(clk), .rst_n_s(rst_n_s), .phase_o(phase_o), .boundary(boundary));

  fseq_next_pc #(.PC_W(PC_W), .LOW_W(LOW_W)) u_nx (
    .pc(pc), .ev(ev), .call_req(call_req), .jmp_req(jmp_req),
    .ret_req(ret_req), .pcl_wr(pcl_wr), .skip_req(skip_req),
    .irq_req(irq_req), .tgt_addr(tgt_addr), .ret_addr(ret_addr),
    .pcl_data(pcl_data), .irq_vec(irq_vec), .pc_nx(pc_nx), .ev_nx(ev_nx),
    .push_req(push_req), .push_addr(push_addr), .sel(sel));

  always_comb begin
    pc_d  = pc;
    ev_d  = ev;
    ins_d = ins;
    if (boundary) begin
      pc_d  = pc_nx;
      ev_d  = ev_nx;
      ins_d = instr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      pc  <= '0;
      ev  <= 1'b0;
      ins <= '0;
    end else begin
      pc  <= pc_d;
      ev  <= ev_d;
      ins <= ins_d;
    end
  end

  assign fetch_stb  = phase_o[0];
  assign fetch_addr = pc;
  assign exec_valid = ev;
  assign exec_instr = ins;
  assign push_stb   = boundary && push_req;

  // R4: program counter moves only on the T4-to-T1 edge
  p_pc_hold_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    !boundary |=> $stable(pc) && $stable(ev));

  // R5: plain increment keeps the pipeline full
  p_seq_inc_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (boundary && sel == NX_INC) |=> (ev && pc == $past(pc) + PC_W'(1)));

  // R9: a taken interrupt lands on the vector with a dead execute slot
  p_irq_squash_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (boundary && sel == NX_IRQ) |=> (!ev && pc == $past(irq_vec)));

  // R3: no fetch and no push before the pipeline runs
  p_idle_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (phase_o == 4'b0000) |-> (!fetch_stb && !push_stb && !ev));
endmodule

// File: tb/sim_fetch_sequencer.sv
`timescale 1ns/1ps
module sim_fetch_sequencer;
  localparam int PC_W = 10, LOW_W = 4, IW = 8, STARTUP = 20;

  logic             clk = 1'b0, rst_n = 1'b0;
  logic [IW-1:0]    instr_i;
  logic             call_req = 0, jmp_req = 0, ret_req = 0, pcl_wr = 0, skip_req = 0, irq_req = 0;
  logic [PC_W-1:0]  tgt_addr = '0, ret_addr = '0, irq_vec = '0;
  logic [LOW_W-1:0] pcl_data = '0;
  logic [3:0]       phase_o;
  logic             fetch_stb, exec_valid, push_stb;
  logic [PC_W-1:0]  fetch_addr, push_addr;
  logic [IW-1:0]    exec_instr;

  int total = 0, bad = 0;
  logic done = 1'b0;

  logic [PC_W-1:0] m_pc;
  logic            m_ev;
  logic [IW-1:0]   m_ins;
  logic [15:0]     lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  function automatic logic [IW-1:0] word_at(input logic [PC_W-1:0] a);
    return a[7:0] ^ {a[9:8], 6'h15};
  endfunction

  assign instr_i = word_at(fetch_addr);

  fetch_sequencer #(.PC_W(PC_W), .LOW_W(LOW_W), .IW(IW), .STARTUP(STARTUP)) u0 (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .call_req(call_req),
    .jmp_req(jmp_req), .ret_req(ret_req), .pcl_wr(pcl_wr), .skip_req(skip_req),
    .irq_req(irq_req), .tgt_addr(tgt_addr), .ret_addr(ret_addr),
    .pcl_data(pcl_data), .irq_vec(irq_vec), .phase_o(phase_o),
    .fetch_stb(fetch_stb), .fetch_addr(fetch_addr), .exec_valid(exec_valid),
    .exec_instr(exec_instr), .push_stb(push_stb), .push_addr(push_addr));

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one instruction cycle; starts and ends at the negedge inside T1
  // req = {irq, call, jmp, ret, pcl, skip}
  task automatic cycle(input logic [5:0] req, input string tag);
    logic c, j, r, p, s, flow, take, e_push;
    logic [PC_W-1:0] tv, resume, e_paddr, n_pc;
    logic n_ev;
    chk(phase_o == 4'b0001, "R1 phase T1", phase_o, 4'b0001);
    chk(fetch_stb == 1'b1, "R4 fetch_stb in T1", fetch_stb, 1);
    chk(fetch_addr == m_pc, {"R5/R6/R9 fetch_addr ", tag}, fetch_addr, m_pc);
    chk(exec_valid == m_ev, {"R6/R7/R9 exec_valid ", tag}, exec_valid, m_ev);
    if (m_ev) chk(exec_instr == m_ins, "R5 exec_instr", exec_instr, m_ins);
    {irq_req, call_req, jmp_req, ret_req, pcl_wr, skip_req} = req;
    @(negedge clk);
    chk(phase_o == 4'b0010 && !fetch_stb, "R1/R4 phase T2", phase_o, 4'b0010);
    @(negedge clk);
    chk(phase_o == 4'b0100, "R1 phase T3", phase_o, 4'b0100);
    @(negedge clk);
    chk(phase_o == 4'b1000 && !fetch_stb, "R1/R4 phase T4", phase_o, 4'b1000);
    chk(fetch_addr == m_pc, "R4 fetch_addr stable", fetch_addr, m_pc);
    // model
    c = m_ev & req[4]; j = m_ev & req[3]; r = m_ev & req[2];
    p = m_ev & req[1]; s = m_ev & req[0];
    flow = c | j | r | p;
    tv = (c | j) ? tgt_addr : r ? ret_addr : {m_pc[PC_W-1:LOW_W], pcl_data};
    take = req[5] & ~c;
    resume = flow ? tv : s ? m_pc + 1'b1 : m_pc;
    e_push = take | c;
    e_paddr = take ? resume : m_pc;
    chk(push_stb == e_push, {"R9/R10 push_stb ", tag}, push_stb, e_push);
    if (e_push) chk(push_addr == e_paddr, {"R9/R10 push_addr ", tag}, push_addr, e_paddr);
    if (take)      begin n_pc = irq_vec; n_ev = 1'b0; end
    else if (flow) begin n_pc = tv;      n_ev = 1'b0; end
    else           begin n_pc = m_pc + 1'b1; n_ev = ~s; end
    m_ins = word_at(m_pc);
    m_pc = n_pc;
    m_ev = n_ev;
    @(negedge clk);
    {irq_req, call_req, jmp_req, ret_req, pcl_wr, skip_req} = 6'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    int first;
    repeat (3) @(negedge clk);
    chk(phase_o == 4'b0 && !fetch_stb && !exec_valid && !push_stb, "R3 reset state", phase_o, 0);
    rst_n = 1'b1;
    first = 0;
    for (int k = 1; k <= 200; k++) begin
      @(posedge clk); @(negedge clk);
      if (fetch_stb) begin first = k; break; end
      chk(phase_o == 4'b0 && !exec_valid && !push_stb, "R2/R3 hold-off quiet", phase_o, 0);
    end
    chk(first == STARTUP + 2, "R2 hold-off length", first, STARTUP + 2);
    chk(fetch_addr == 0 && !exec_valid, "R3 first fetch at 0 with dead slot", fetch_addr, 0);
    m_pc = '0; m_ev = 1'b0; m_ins = '0;

    cycle(6'b000000, "R3 first");
    cycle(6'b000000, "R5 seq");
    tgt_addr = 10'h040; cycle(6'b001000, "R6 jump");
    tgt_addr = 10'h100; cycle(6'b001001, "R8 jump+skip in bubble");
    cycle(6'b000001, "R7 skip");
    cycle(6'b000000, "R7 after skip");
    pcl_data = 4'h9; cycle(6'b000010, "R6 pcl");
    cycle(6'b000000, "R6 bubble"); cycle(6'b000000, "R5 seq");
    ret_addr = 10'h2F0; cycle(6'b000100, "R6 ret");
    cycle(6'b000000, "R6 bubble"); cycle(6'b000000, "R5 seq");
    tgt_addr = 10'h080; cycle(6'b010000, "R10 call");
    cycle(6'b000000, "R6 bubble"); cycle(6'b000000, "R5 seq");
    irq_vec = 10'h3C0; cycle(6'b100000, "R9 irq idle");
    cycle(6'b000000, "R9 bubble"); cycle(6'b000000, "R5 seq");
    tgt_addr = 10'h155; cycle(6'b110000, "R9 irq defer behind call");
    cycle(6'b100000, "R9 irq in bubble");
    cycle(6'b000000, "R9 bubble"); cycle(6'b000000, "R5 seq");
    cycle(6'b100001, "R9 irq+skip resume");
    cycle(6'b000000, "R9 bubble"); cycle(6'b000000, "R5 seq");
    tgt_addr = 10'h222; ret_addr = 10'h333; pcl_data = 4'h6;
    cycle(6'b011111, "R11 call wins");
    cycle(6'b000000, "R6 bubble"); cycle(6'b000000, "R5 seq");
    cycle(6'b001111, "R11 jump over ret/pcl/skip");
    cycle(6'b000000, "R6 bubble"); cycle(6'b000000, "R5 seq");
    cycle(6'b000111, "R11 ret over pcl/skip");
    cycle(6'b000000, "R6 bubble"); cycle(6'b000000, "R5 seq");
    cycle(6'b000011, "R11 pcl over skip");
    cycle(6'b000000, "R6 bubble"); cycle(6'b000000, "R5 seq");
    tgt_addr = 10'h0AB; cycle(6'b101000, "R11 irq over jump");
    cycle(6'b000000, "R9 bubble");

    for (int n = 0; n < 600; n++) begin
      logic [5:0] rq;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rq = '0;
      for (int b = 0; b < 6; b++) rq[b] = (lfsr[(b * 2) % 16 +: 2] == 2'b00) && lfsr[15 - b];
      tgt_addr = PC_W'(lfsr * 16'd7);
      ret_addr = PC_W'(lfsr ^ 16'h5A5A);
      irq_vec  = PC_W'({lfsr[3:0], 6'h00});
      pcl_data = lfsr[7:4];
      cycle(rq, "R11 random mix");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule